// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo serial audio stream (bit clock, word-select clock, serial data) into parallel sample pairs. It is a slave of the bit clock: its own clock is the incoming bit clock. On every rising edge it samples both the word-select line and the data line. It never drives either clock.

A 3-bit format code picks one of seven frame layouts: right-aligned (LSB-justified), left-aligned (MSB-justified) or I2S-compatible, with word lengths of 16, 20 or 24 bits. The code is captured only while reset is held. After each complete stereo frame the block presents a left and right sample as SAMPLE_W-bit two's complement values, together with a one-cycle valid strobe. Right-aligned frames may be longer than the word. The block keeps a running shift register and takes the last bits before each word-select transition, so it needs no bit count from the edge.

Top module: `srx_serial_rx`

## Requirements
- R1: `fmt_code` is captured on every clock while `rst` is high. Once `rst` is low, changes on `fmt_code` have no effect on how frames are decoded.
- R2: Codes 010 and 101 (left-aligned, 24 bits) take the MSB on the first rising clock whose sampled `ws` differs from the previous sample. The left channel is carried while `ws` is 1. Data is MSB first, and bits after the 24th of a half-frame are ignored.
- R3: Codes 011 and 110 (I2S, 24 bits) take the MSB on the second rising clock after the transition, and the left channel is carried while `ws` is 0. The bit sampled on the first clock after a transition completes the preceding word, so 24-bit words in 24-clock half-frames decode correctly.
- R4: A word with fewer than SAMPLE_W bits in a left-aligned or I2S layout is placed at the top of the output, with zeros below. This covers 16-bit I2S words in 16-clock half-frames under code 011.
- R5: Codes 000, 001 and 100 (right-aligned, 16, 20 and 24 bits) take the last W bits sampled before the transition that ends the half-frame. The left channel is carried while `ws` is 1, and the value is sign-extended to SAMPLE_W bits.
- R6: In right-aligned layouts, half-frames longer than the word decode the same value: the leading padding bits are ignored.
- R7: `valid` pulses for exactly one cycle, in the cycle after the clock that sampled the transition ending a right half-frame. `left` and `right` hold their values between pulses.
- R8: Code 111 produces all-zero samples. Its strobe timing follows the left-on-`ws`-high polarity.
- R9: While `rst` is high and after its release, `valid`, `left` and `right` are 0. The half-frame in progress at release is discarded. The first pair is issued only after one complete left half-frame followed by one complete right half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; data and word select are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset and power-down; format code is captured while high |
| fmt_code | input | CODE_W | Frame layout selector |
| ws | input | 1 | Word-select (channel) clock |
| sdata | input | 1 | Serial data, MSB first, two's complement |
| left | output | SAMPLE_W | Left sample of the last complete frame |
| right | output | SAMPLE_W | Right sample of the last complete frame |
| valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Each layout is driven with frames whose unused bit slots are filled with ones. Any misplaced capture window therefore shows up as corrupted samples, not as silent zeros. Left-aligned and I2S streams are run with both exact and longer half-frames. The 24-clock I2S case separates correct handling of the carried last bit from a design that restarts its count at the edge. Right-aligned streams use negative and positive words at exact and padded lengths, which tells right alignment and sign extension apart from counting from the edge. Further runs cover the reserved code, a format code changed after reset, and output hold between strobes.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [1:0] {
      LAY_RIGHT = 2'd0,
      LAY_LEFT  = 2'd1,
      LAY_I2S   = 2'd2,
      LAY_OFF   = 2'd3
   } lay_e;

   typedef struct packed {
      lay_e       lay;
      logic [1:0] wsel;      // word-length index for right-aligned layouts
      logic       left_low;  // 1: left channel carried while ws is 0
   } fmt_t;

   localparam int NUM_WIDTHS = 3;

   function automatic int width_of(input int idx);
      return 16 + 4 * idx;
   endfunction

   function automatic fmt_t decode(input logic [2:0] code);
      fmt_t f;
      f = '{lay: LAY_OFF, wsel: 2'd2, left_low: 1'b0};
      case (code)
         3'b000:  f = '{lay: LAY_RIGHT, wsel: 2'd0, left_low: 1'b0};
         3'b001:  f = '{lay: LAY_RIGHT, wsel: 2'd1, left_low: 1'b0};
         3'b010:  f = '{lay: LAY_LEFT,  wsel: 2'd2, left_low: 1'b0};
         3'b011:  f = '{lay: LAY_I2S,   wsel: 2'd2, left_low: 1'b1};
         3'b100:  f = '{lay: LAY_RIGHT, wsel: 2'd2, left_low: 1'b0};
         3'b101:  f = '{lay: LAY_LEFT,  wsel: 2'd2, left_low: 1'b0};
         3'b110:  f = '{lay: LAY_I2S,   wsel: 2'd2, left_low: 1'b1};
         default: f = '{lay: LAY_OFF,   wsel: 2'd2, left_low: 1'b0};
      endcase
      return f;
   endfunction

endpackage

// File: rtl/srx_fmt_latch.sv
module srx_fmt_latch
   import srx_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] code_i,
   output fmt_t              fmt_o
);

   if (CODE_W != 3) begin : g_code_chk
      $error("srx_fmt_latch: CODE_W must be 3");
   end

   logic [CODE_W-1:0] code_q;

   // Format is frozen outside reset (R1)
   always_ff @(posedge clk) begin
      if (rst) code_q <= code_i;
   end

   assign fmt_o = decode(code_q[2:0]);

endmodule

// File: rtl/srx_slot_asm.sv
module srx_slot_asm #(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                edge_i,
   input  logic                i2s_i,
   input  logic                sd_i,
   output logic [SAMPLE_W-1:0] word_o
);

   localparam int CNT_W = $clog2(SAMPLE_W + 1);

   logic [SAMPLE_W-1:0] acc, acc_n;
   logic [CNT_W-1:0]    cnt, cnt_n;
   logic                room;

   assign room = (cnt < CNT_W'(SAMPLE_W));

   // Finished word: in I2S the bit at the edge closes the old word
   always_comb begin
      word_o = acc;
      if (i2s_i && room) begin
         for (int b = 0; b < SAMPLE_W; b++) begin
            if (cnt == CNT_W'(SAMPLE_W - 1 - b)) word_o[b] = sd_i;
         end
      end
   end

   always_comb begin
      acc_n = acc;
      cnt_n = cnt;
      if (edge_i) begin
         acc_n = '0;
         cnt_n = '0;
         if (!i2s_i) begin
            acc_n[SAMPLE_W-1] = sd_i;
            cnt_n = CNT_W'(1);
         end
      end else if (room) begin
         for (int b = 0; b < SAMPLE_W; b++) begin
            if (cnt == CNT_W'(SAMPLE_W - 1 - b)) acc_n[b] = sd_i;
         end
         cnt_n = cnt + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc <= '0;
         cnt <= '0;
      end else begin
         acc <= acc_n;
         cnt <= cnt_n;
      end
   end

   p_i2s_skip_r3: assert property (@(posedge clk) disable iff (rst)
      (edge_i && i2s_i) |=> (cnt == '0));

   p_msb_first_r2: assert property (@(posedge clk) disable iff (rst)
      (edge_i && !i2s_i) |=> (acc[SAMPLE_W-1] == $past(sd_i)));

endmodule

// File: rtl/srx_lsb_align.sv
module srx_lsb_align
   import srx_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                sd_i,
   input  logic [1:0]          wsel_i,
   output logic [SAMPLE_W-1:0] word_o
);

   localparam int MAX_W = width_of(NUM_WIDTHS - 1);

   if (SAMPLE_W < MAX_W) begin : g_w_chk
      $error("srx_lsb_align: SAMPLE_W narrower than widest word");
   end

   logic [MAX_W-1:0]    sh;
   logic [SAMPLE_W-1:0] cand [NUM_WIDTHS];

   always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[MAX_W-2:0], sd_i};
   end

   for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_cand
      localparam int W = width_of(gi);
      if (SAMPLE_W > W) begin : g_ext
         assign cand[gi] = {{(SAMPLE_W - W){sh[W-1]}}, sh[W-1:0]};
      end else begin : g_full
         assign cand[gi] = sh[W-1:0];
      end
   end

   always_comb begin
      word_o = '0;
      for (int gi = 0; gi < NUM_WIDTHS; gi++) begin
         if (wsel_i == 2'(gi)) word_o = cand[gi];
      end
   end

endmodule

// File: rtl/srx_serial_rx.sv
module srx_serial_rx
   import srx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int CODE_W   = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [CODE_W-1:0]   fmt_code,
   input  logic                ws,
   input  logic                sdata,
   output logic [SAMPLE_W-1:0] left,
   output logic [SAMPLE_W-1:0] right,
   output logic                valid
);

   if (SAMPLE_W < 24) begin : g_sw_chk
      $error("srx_serial_rx: SAMPLE_W must be at least 24");
   end

   fmt_t                fmt;
   logic                ws_q, started, primed, left_ok;
   logic                ws_edge, ending_left;
   logic [SAMPLE_W-1:0] left_hold, asm_word, lsb_word, fin_word;

   srx_fmt_latch #(.CODE_W(CODE_W)) u_fmt (
      .clk(clk), .rst(rst), .code_i(fmt_code), .fmt_o(fmt)
   );

   srx_slot_asm #(.SAMPLE_W(SAMPLE_W)) u_asm (
      .clk(clk), .rst(rst), .edge_i(ws_edge),
      .i2s_i(fmt.lay == LAY_I2S), .sd_i(sdata), .word_o(asm_word)
   );

   srx_lsb_align #(.SAMPLE_W(SAMPLE_W)) u_lsb (
      .clk(clk), .rst(rst), .sd_i(sdata), .wsel_i(fmt.wsel), .word_o(lsb_word)
   );

   assign ws_edge     = started && (ws != ws_q);
   assign ending_left = fmt.left_low ? !ws_q : ws_q;

   always_comb begin
      case (fmt.lay)
         LAY_RIGHT: fin_word = lsb_word;
         LAY_LEFT,
         LAY_I2S:   fin_word = asm_word;
         default:   fin_word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ws_q      <= 1'b0;
         started   <= 1'b0;
         primed    <= 1'b0;
         left_ok   <= 1'b0;
         left_hold <= '0;
         left      <= '0;
         right     <= '0;
         valid     <= 1'b0;
      end else begin
         started <= 1'b1;
         ws_q    <= ws;
         valid   <= 1'b0;
         if (ws_edge) begin
            primed <= 1'b1;
            if (primed) begin
               if (ending_left) begin
                  left_hold <= fin_word;
                  left_ok   <= 1'b1;
               end else begin
                  left_ok <= 1'b0;
                  if (left_ok) begin
                     left  <= left_hold;
                     right <= fin_word;
                     valid <= 1'b1;
                  end
               end
            end
         end
      end
   end

   p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      valid |=> !valid);

   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !valid |-> ($stable(left) && $stable(right)));

   p_valid_edge_r7: assert property (@(posedge clk) disable iff (rst)
      valid |-> ($past(ws) != $past(ws, 2)));

   p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!valid && left == '0 && right == '0));

   p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (fmt.lay == LAY_OFF) |-> (left == '0 && right == '0));

endmodule

// File: tb/srx_serial_rx_test.sv
module srx_serial_rx_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  fmt_code = 3'b000;
   logic        ws = 1'b0;
   logic        sdata = 1'b0;
   logic [23:0] left, right;
   logic        valid;

   int n_chk = 0, n_bad = 0, rx = 0, cyc = 0;
   logic [23:0] tl [8], tr [8], gl [8], gr [8];

   srx_serial_rx uut (
      .clk(clk), .rst(rst), .fmt_code(fmt_code), .ws(ws), .sdata(sdata),
      .left(left), .right(right), .valid(valid)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      if (!rst && valid) begin
         if (rx < 8) begin
            gl[rx] = left;
            gr[rx] = right;
         end
         rx++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung act=%0d exp<150000 cycles", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] expect_val(input int lay, input int w, input logic [23:0] word);
      logic [23:0] m;
      m = (24'h1 << w) - 24'h1;
      case (lay)
         0: return (word[w-1]) ? (word | ~m) : (word & m);
         1, 2: return (word & m) << (24 - w);
         default: return 24'h0;
      endcase
   endfunction

   task automatic do_reset(input logic [2:0] code);
      @(negedge clk);
      rst = 1'b1;
      fmt_code = code;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // lay: 0 right-aligned, 1 left-aligned, 2 I2S, 3 reserved (driven as left-aligned)
   task automatic stream(input string req, input logic [2:0] code, input logic [2:0] run_code,
                         input int lay, input int w, input int hl, input int n, input int exp_lay);
      logic lpol, carry, b;
      logic [23:0] word;
      do_reset(code);
      fmt_code = run_code;
      rx = 0;
      lpol = (lay == 2) ? 1'b0 : 1'b1;
      carry = 1'b1;
      for (int f = 0; f < n; f++) begin
         tl[f] = (24'h9A5C31 ^ (24'h13579 * f)) & ((24'h1 << w) - 24'h1);
         tr[f] = (24'h25E7C4 + (24'h0B3D1 * f)) & ((24'h1 << w) - 24'h1);
      end
      ws = ~lpol;
      sdata = 1'b1;
      repeat (5) @(negedge clk);
      for (int f = 0; f <= n; f++) begin
         for (int ch = 0; ch < 2; ch++) begin
            if (f == n && ch == 1) break;
            word = (f == n) ? 24'h0 : (ch == 0 ? tl[f] : tr[f]);
            for (int k = 0; k < hl; k++) begin
               case (lay)
                  0: b = (k >= hl - w) ? word[hl-1-k] : 1'b1;
                  2: b = (k == 0) ? carry : ((k <= w) ? word[w-k] : 1'b1);
                  default: b = (k < w) ? word[w-1-k] : 1'b1;
               endcase
               ws = (ch == 0) ? lpol : ~lpol;
               sdata = b;
               @(negedge clk);
            end
            carry = (w == hl) ? word[0] : 1'b1;
         end
      end
      repeat (4) @(negedge clk);
      chk({req, " frame count"}, 24'(rx), 24'(n));
      for (int f = 0; f < n && f < rx; f++) begin
         chk({req, " left"}, gl[f], expect_val(exp_lay, w, tl[f]));
         chk({req, " right"}, gr[f], expect_val(exp_lay, w, tr[f]));
      end
      // R7: outputs hold the last pair, strobe low
      repeat (6) @(negedge clk);
      chk("R7 strobe low between frames", {23'h0, valid}, 24'h0);
      chk("R7 left held", left, expect_val(exp_lay, w, tl[n-1]));
      chk("R7 right held", right, expect_val(exp_lay, w, tr[n-1]));
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 valid in reset", {23'h0, valid}, 24'h0);
      chk("R9 left in reset", left, 24'h0);
      chk("R9 right in reset", right, 24'h0);
   endtask

   initial begin
      t_reset_state();
      stream("R2 code010 hl24",  3'b010, 3'b010, 1, 24, 24, 3, 1);
      stream("R2 code101 hl32",  3'b101, 3'b101, 1, 24, 32, 3, 1);
      stream("R3 code011 hl24",  3'b011, 3'b011, 2, 24, 24, 3, 2);
      stream("R3 code110 hl32",  3'b110, 3'b110, 2, 24, 32, 3, 2);
      stream("R4 code011 16bit", 3'b011, 3'b011, 2, 16, 16, 3, 2);
      stream("R5 code000 hl16",  3'b000, 3'b000, 0, 16, 16, 3, 0);
      stream("R6 code000 hl32",  3'b000, 3'b000, 0, 16, 32, 3, 0);
      stream("R5 code001 hl20",  3'b001, 3'b001, 0, 20, 20, 3, 0);
      stream("R6 code001 hl32",  3'b001, 3'b001, 0, 20, 32, 3, 0);
      stream("R5 code100 hl24",  3'b100, 3'b100, 0, 24, 24, 3, 0);
      stream("R6 code100 hl32",  3'b100, 3'b100, 0, 24, 32, 3, 0);
      stream("R8 code111",       3'b111, 3'b111, 3, 24, 32, 2, 3);
      stream("R1 code frozen",   3'b010, 3'b000, 1, 24, 32, 2, 1);
      t_reset_state();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule